// File: doc/BRIEF.md
# Legacy Configuration Port Decoder

This block sits on the host side of a bridge. It watches a simple processor I/O bus and turns certain port reads and writes into configuration-space requests for downstream devices. Two legacy access styles are supported, chosen by a static mode input. In the first style, software loads a 32-bit target register and then touches a fixed data port. In the second style, software opens a mapped window by writing a function-select byte and a bus-number byte. Each device's registers then appear directly in a 4 KB range of I/O space.

Any I/O access that becomes a configuration request stalls the I/O bus through `io_wait`. The request goes out on a valid/ready channel. `req_valid` and every request field stay stable until the downstream side raises `req_ready`. Only one request is outstanding at a time. The downstream side completes it by pulsing `rsp_valid` for one cycle with read data; writes also need this pulse. The I/O access finishes in the cycle after that pulse. An I/O access is taken at every rising edge where a strobe is high and `io_wait` is low. The host drops the strobe after that edge. Accesses that produce no request finish with no wait. Address bits 1:0 are ignored; byte lanes are chosen by `io_be`.

Top module: `cfg_port_decoder`

## Requirements
- R1: After reset the target register, the function-select byte and the bus-number byte are all 0, `io_wait` and `req_valid` are low, and reading port 0x0CF8 returns 0 in mode 1 and in mode 2.
- R2: Mode encoding is 1 for the address/data pair. In this mode a write to the dword at 0x0CF8 with all four byte enables stores the bits under mask 0x80FFFFFC. A read of that dword returns the stored value, with the other bits reading 0.
- R3: In mode 1, a write to the dword at 0x0CF8 with any byte enable clear leaves the target register unchanged.
- R4: In mode 1, with bit 31 of the target register set, a read or write to the dword at 0x0CFC produces a request with these fields: bus = bits 23:16, device = bits 15:11, function = bits 10:8, register = bits 7:2. `io_be` and `io_wdata` pass through unchanged.
- R5: In mode 1, with bit 31 clear, a data-port access produces no request. A read returns 0xFFFFFFFF and a write is dropped.
- R6: Mode encoding is 2 for the mapped window. In this mode the function-select byte is written through byte lane 0 of the dword at 0x0CF8. The bus-number byte is written through lane 2, which is port 0x0CFA. A read of that dword returns {8'h00, bus byte, 8'h00, select byte}, and 0 reads back as 0.
- R7: In mode 2, the window is open when the select byte's bits 7:4 are all ones. While it is open, an access to 0xCDRR produces a request with these fields: bus = bus byte, device = D (0 to 15), function = select bits 3:1, register = address bits 7:2.
- R8: In mode 2, with the window closed, an access to 0xCxxx produces no request. A read returns 0xFFFFFFFF.
- R9: Any address not claimed by the active mode returns 0xFFFFFFFF on a read, drops a write, and never asserts `io_wait`.
- R10: From the cycle the access is seen until the cycle after `rsp_valid`, `io_wait` stays high, so the stall lasts 3 cycles plus the downstream ready delay. `req_valid` and its fields hold until accepted. No second request follows an accepted one. The I/O read completes with `rsp_rdata`.
- R11: Modes 0 and 3 claim no address: all reads return 0xFFFFFFFF and no request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 off, 1 address/data pair, 2 mapped window, 3 off |
| io_addr | input | 16 | I/O port address |
| io_be | input | 4 | I/O byte enables |
| io_wdata | input | 32 | I/O write data |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_rdata | output | 32 | I/O read data, valid when a read completes |
| io_wait | output | 1 | Stalls the I/O access |
| req_valid | output | 1 | Configuration request valid |
| req_ready | input | 1 | Downstream accepts the request |
| req_write | output | 1 | 1 write, 0 read |
| req_bus | output | 8 | Target bus number |
| req_dev | output | 5 | Target device number |
| req_fn | output | 3 | Target function number |
| req_reg | output | 6 | Dword register index |
| req_be | output | 4 | Byte enables |
| req_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | One-cycle completion pulse |
| rsp_rdata | input | 32 | Read data returned with completion |

## Verification
The in-line assertions check the handshake rules on every cycle:
- A pending request holds its fields.
- No request follows directly on an accepted one.
- A request never appears without a stall.
- A partial write never alters the mode-1 target register.
- The select byte ignores writes whose lane 0 is off.
- An inactive mode never stalls the bus.

The field extraction from both mechanisms, the read-back masks, the window open and close behaviour and the exact stall length can only be shown by the bench's access sequences. There, each expected value follows from the register contents written earlier.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;
  localparam int AW    = 16;
  localparam int DW    = 32;
  localparam int BEW   = DW / 8;
  localparam int BUS_W = 8;
  localparam int DEV_W = 5;
  localparam int FN_W  = 3;
  localparam int REG_W = 6;
  localparam int DWA_W = AW - 2;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_PAIR = 2'd1,
    MODE_WIN  = 2'd2,
    MODE_RSVD = 2'd3
  } cfg_mode_e;

  typedef struct packed {
    logic             write;
    logic [BUS_W-1:0] bus;
    logic [DEV_W-1:0] dev;
    logic [FN_W-1:0]  fn;
    logic [REG_W-1:0] dreg;
    logic [BEW-1:0]   be;
    logic [DW-1:0]    wdata;
  } cfg_req_t;
endpackage

// File: rtl/cfgdec_pair.sv
module cfgdec_pair
  import cfgdec_pkg::*;
#(
  parameter logic [AW-1:0] ADDR_PORT = 16'h0CF8,
  parameter logic [AW-1:0] DATA_PORT = 16'h0CFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             acc_idle,
  input  logic [DWA_W-1:0] dw_addr,
  input  logic [BEW-1:0]   io_be,
  input  logic [DW-1:0]    io_wdata,
  input  logic             io_rd,
  input  logic             io_wr,
  output logic             reg_hit,
  output logic [DW-1:0]    reg_rdata,
  output logic             cfg_hit,
  output logic [BUS_W-1:0] tgt_bus,
  output logic [DEV_W-1:0] tgt_dev,
  output logic [FN_W-1:0]  tgt_fn,
  output logic [REG_W-1:0] tgt_reg
);
  localparam logic [DW-1:0] KEEP_MASK = 32'h80FF_FFFC;
  localparam int EN_BIT = DW - 1;
  localparam int BUS_LO = 16;
  localparam int DEV_LO = 11;
  localparam int FN_LO  = 8;
  localparam int REG_LO = 2;

  logic [DW-1:0] tgt_q;
  logic          data_hit;
  logic          full_wr;

  assign reg_hit  = sel && (dw_addr == ADDR_PORT[AW-1:2]);
  assign data_hit = sel && (dw_addr == DATA_PORT[AW-1:2]);
  assign full_wr  = acc_idle && io_wr && reg_hit && (io_be == {BEW{1'b1}});
  assign cfg_hit  = data_hit && tgt_q[EN_BIT] && (io_rd || io_wr);

  always_ff @(posedge clk) begin
    if (!rst_n) tgt_q <= '0;
    else if (full_wr) tgt_q <= io_wdata & KEEP_MASK;
  end

  assign reg_rdata = tgt_q;
  assign tgt_bus   = tgt_q[BUS_LO +: BUS_W];
  assign tgt_dev   = tgt_q[DEV_LO +: DEV_W];
  assign tgt_fn    = tgt_q[FN_LO +: FN_W];
  assign tgt_reg   = tgt_q[REG_LO +: REG_W];

  // R3: a write narrower than 32 bits never alters the target register
  assert_partial_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && reg_hit && (io_be != {BEW{1'b1}})) |=> $stable(tgt_q));
endmodule

// File: rtl/cfgdec_window.sv
module cfgdec_window
  import cfgdec_pkg::*;
#(
  parameter logic [AW-1:0] CTRL_PORT   = 16'h0CF8,
  parameter logic [3:0]    WIN_NIBBLE  = 4'hC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             acc_idle,
  input  logic [DWA_W-1:0] dw_addr,
  input  logic [BEW-1:0]   io_be,
  input  logic [DW-1:0]    io_wdata,
  input  logic             io_rd,
  input  logic             io_wr,
  output logic             reg_hit,
  output logic [DW-1:0]    reg_rdata,
  output logic             cfg_hit,
  output logic [BUS_W-1:0] tgt_bus,
  output logic [DEV_W-1:0] tgt_dev,
  output logic [FN_W-1:0]  tgt_fn,
  output logic [REG_W-1:0] tgt_reg
);
  localparam int SEL_LANE = 0;
  localparam int FWD_LANE = 2;
  localparam int DEVN_W   = 4;
  localparam int NIB_LO   = DWA_W - 4;

  logic [7:0] sel_q;
  logic [7:0] fwd_q;
  logic       win_open;
  logic       win_addr;

  assign reg_hit  = sel && (dw_addr == CTRL_PORT[AW-1:2]);
  assign win_open = (sel_q[7:4] == 4'hF);
  assign win_addr = (dw_addr[NIB_LO +: 4] == WIN_NIBBLE);
  assign cfg_hit  = sel && win_open && win_addr && (io_rd || io_wr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      fwd_q <= '0;
    end else if (acc_idle && io_wr && reg_hit) begin
      if (io_be[SEL_LANE]) sel_q <= io_wdata[SEL_LANE*8 +: 8];
      if (io_be[FWD_LANE]) fwd_q <= io_wdata[FWD_LANE*8 +: 8];
    end
  end

  assign reg_rdata = {8'h00, fwd_q, 8'h00, sel_q};
  assign tgt_bus   = fwd_q;
  assign tgt_dev   = {{(DEV_W-DEVN_W){1'b0}}, dw_addr[NIB_LO-1 -: DEVN_W]};
  assign tgt_fn    = sel_q[1 +: FN_W];
  assign tgt_reg   = dw_addr[REG_W-1:0];

  // R6: the select byte only changes through lane 0
  assert_lane_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && reg_hit && !io_be[SEL_LANE]) |=> $stable(sel_q));
endmodule

// File: rtl/cfgdec_xfer.sv
module cfgdec_xfer
  import cfgdec_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  cfg_req_t      req_in,
  input  logic          req_ready,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_rdata,
  output logic          req_valid,
  output cfg_req_t      req_out,
  output logic          io_wait,
  output logic          done,
  output logic          idle,
  output logic [DW-1:0] rdata_q
);
  typedef enum logic [1:0] {X_IDLE, X_REQ, X_RSP, X_DONE} xst_e;
  xst_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= X_IDLE;
      req_out <= '0;
      rdata_q <= '0;
    end else begin
      case (st_q)
        X_IDLE: if (start) begin
          req_out <= req_in;
          st_q    <= X_REQ;
        end
        X_REQ:  if (req_ready) st_q <= X_RSP;
        X_RSP:  if (rsp_valid) begin
          rdata_q <= rsp_rdata;
          st_q    <= X_DONE;
        end
        default: st_q <= X_IDLE;
      endcase
    end
  end

  assign idle      = (st_q == X_IDLE);
  assign done      = (st_q == X_DONE);
  assign req_valid = (st_q == X_REQ);
  assign io_wait   = (idle && start) || (st_q == X_REQ) || (st_q == X_RSP);

  // R10: a pending request keeps its fields until accepted
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_out)));
  // R10: one outstanding request only
  assert_single_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_valid);
  // R10: the I/O bus is stalled whenever a request is offered
  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> io_wait);
endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
  import cfgdec_pkg::*;
#(
  parameter logic [15:0] PAIR_ADDR_PORT  = 16'h0CF8,
  parameter logic [15:0] PAIR_DATA_PORT  = 16'h0CFC,
  parameter logic [15:0] WIN_CTRL_PORT   = 16'h0CF8,
  parameter logic [3:0]  WIN_BASE_NIBBLE = 4'hC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  mode,
  input  logic [15:0] io_addr,
  input  logic [3:0]  io_be,
  input  logic [31:0] io_wdata,
  input  logic        io_rd,
  input  logic        io_wr,
  output logic [31:0] io_rdata,
  output logic        io_wait,
  output logic        req_valid,
  input  logic        req_ready,
  output logic        req_write,
  output logic [7:0]  req_bus,
  output logic [4:0]  req_dev,
  output logic [2:0]  req_fn,
  output logic [5:0]  req_reg,
  output logic [3:0]  req_be,
  output logic [31:0] req_wdata,
  input  logic        rsp_valid,
  input  logic [31:0] rsp_rdata
);
  localparam logic [DW-1:0] NO_DEV = {DW{1'b1}};

  cfg_mode_e        mode_e;
  logic [DWA_W-1:0] dw_addr;
  logic             sel_pair, sel_win, acc_idle, x_done, start;
  logic             p_reg_hit, p_cfg_hit, w_reg_hit, w_cfg_hit;
  logic [DW-1:0]    p_rdata, w_rdata, x_rdata;
  logic [BUS_W-1:0] p_bus, w_bus;
  logic [DEV_W-1:0] p_dev, w_dev;
  logic [FN_W-1:0]  p_fn, w_fn;
  logic [REG_W-1:0] p_reg, w_reg;
  cfg_req_t         req_in, req_q;

  assign mode_e   = cfg_mode_e'(mode);
  assign dw_addr  = io_addr[AW-1:2];
  assign sel_pair = (mode_e == MODE_PAIR);
  assign sel_win  = (mode_e == MODE_WIN);

  cfgdec_pair #(.ADDR_PORT(PAIR_ADDR_PORT), .DATA_PORT(PAIR_DATA_PORT)) u_pair (
    .clk(clk), .rst_n(rst_n), .sel(sel_pair), .acc_idle(acc_idle),
    .dw_addr(dw_addr), .io_be(io_be), .io_wdata(io_wdata),
    .io_rd(io_rd), .io_wr(io_wr),
    .reg_hit(p_reg_hit), .reg_rdata(p_rdata), .cfg_hit(p_cfg_hit),
    .tgt_bus(p_bus), .tgt_dev(p_dev), .tgt_fn(p_fn), .tgt_reg(p_reg)
  );

  cfgdec_window #(.CTRL_PORT(WIN_CTRL_PORT), .WIN_NIBBLE(WIN_BASE_NIBBLE)) u_win (
    .clk(clk), .rst_n(rst_n), .sel(sel_win), .acc_idle(acc_idle),
    .dw_addr(dw_addr), .io_be(io_be), .io_wdata(io_wdata),
    .io_rd(io_rd), .io_wr(io_wr),
    .reg_hit(w_reg_hit), .reg_rdata(w_rdata), .cfg_hit(w_cfg_hit),
    .tgt_bus(w_bus), .tgt_dev(w_dev), .tgt_fn(w_fn), .tgt_reg(w_reg)
  );

  assign start = p_cfg_hit || w_cfg_hit;

  always_comb begin
    req_in.write = io_wr;
    req_in.be    = io_be;
    req_in.wdata = io_wdata;
    if (sel_win) begin
      req_in.bus  = w_bus;
      req_in.dev  = w_dev;
      req_in.fn   = w_fn;
      req_in.dreg = w_reg;
    end else begin
      req_in.bus  = p_bus;
      req_in.dev  = p_dev;
      req_in.fn   = p_fn;
      req_in.dreg = p_reg;
    end
  end

  cfgdec_xfer u_xfer (
    .clk(clk), .rst_n(rst_n), .start(start), .req_in(req_in),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .req_valid(req_valid), .req_out(req_q), .io_wait(io_wait),
    .done(x_done), .idle(acc_idle), .rdata_q(x_rdata)
  );

  always_comb begin
    if (x_done)         io_rdata = x_rdata;
    else if (p_reg_hit) io_rdata = p_rdata;
    else if (w_reg_hit) io_rdata = w_rdata;
    else                io_rdata = NO_DEV;
  end

  assign req_write = req_q.write;
  assign req_bus   = req_q.bus;
  assign req_dev   = req_q.dev;
  assign req_fn    = req_q.fn;
  assign req_reg   = req_q.dreg;
  assign req_be    = req_q.be;
  assign req_wdata = req_q.wdata;

  // R11 / R9: an inactive mode never stalls the bus from idle
  assert_quiet_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_idle && (mode_e == MODE_OFF || mode_e == MODE_RSVD)) |-> !io_wait);
endmodule

// File: tb/cfg_port_decoder_bench.sv
module cfg_port_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd1;
  logic [15:0] io_addr = '0;
  logic [3:0]  io_be = '0;
  logic [31:0] io_wdata = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [31:0] io_rdata;
  logic        io_wait, req_valid, req_write;
  logic        req_ready = 1'b0, rsp_valid = 1'b0;
  logic [31:0] rsp_rdata = '0;
  logic [7:0]  req_bus;
  logic [4:0]  req_dev;
  logic [2:0]  req_fn;
  logic [5:0]  req_reg;
  logic [3:0]  req_be;
  logic [31:0] req_wdata;

  always #10 clk = ~clk;

  cfg_port_decoder u_cfg_port_decoder (
    .clk(clk), .rst_n(rst_n), .mode(mode), .io_addr(io_addr), .io_be(io_be),
    .io_wdata(io_wdata), .io_rd(io_rd), .io_wr(io_wr), .io_rdata(io_rdata),
    .io_wait(io_wait), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bus(req_bus), .req_dev(req_dev),
    .req_fn(req_fn), .req_reg(req_reg), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic        wr;
    logic [15:0] addr;
    logic [3:0]  be;
    logic [31:0] wdata;
    logic [31:0] rsp;
    logic [1:0]  dly;
    logic        ereq;
    logic [7:0]  ebus;
    logic [4:0]  edev;
    logic [2:0]  efn;
    logic [5:0]  ereg;
    logic [31:0] erd;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{2'd1,1'b1,16'h0CF8,4'hF,32'h8000_0000,32'h0,2'd0,1'b0,8'h00,5'h00,3'd0,6'h00,32'h0,8'd2},          // R2
    '{2'd1,1'b1,16'h0CFB,4'h8,32'h0000_0000,32'h0,2'd0,1'b0,8'h00,5'h00,3'd0,6'h00,32'h0,8'd3},          // R3
    '{2'd1,1'b1,16'h0CFA,4'hC,32'h0000_0000,32'h0,2'd0,1'b0,8'h00,5'h00,3'd0,6'h00,32'h0,8'd3},          // R3
    '{2'd1,1'b0,16'h0CF8,4'hF,32'h0,32'h0,2'd0,1'b0,8'h00,5'h00,3'd0,6'h00,32'h8000_0000,8'd3},          // R3
    '{2'd1,1'b1,16'h0CF8,4'hF,32'hFFFF_FFFF,32'h0,2'd0,1'b0,8'h00,5'h00,3'd0,6'h00,32'h0,8'd2},          // R2
    '{2'd1,1'b0,16'h0CF8,4'hF,32'h0,32'h0,2'd0,1'b0,8'h00,5'h00,3'd0,6'h00,32'h80FF_FFFC,8'd2},          // R2
    '{2'd1,1'b1,16'h0CF8,4'hF,32'h8012_AB44,32'h0,2'd0,1'b0,8'h00,5'h00,3'd0,6'h00,32'h0,8'd4},          // R4
    '{2'd1,1'b0,16'h0CFC,4'hF,32'h0,32'hDEAD_BEEF,2'd2,1'b1,8'h12,5'h15,3'd3,6'h11,32'hDEAD_BEEF,8'd4},  // R4
    '{2'd1,1'b1,16'h0CFE,4'hC,32'h5566_0000,32'h0,2'd0,1'b1,8'h12,5'h15,3'd3,6'h11,32'h0,8'd4},          // R4
    '{2'd1,1'b1,16'h0CF8,4'hF,32'h0,32'h0,2'd0,1'b0,8'h00,5'h00,3'd0,6'h00,32'h0,8'd5},                  // R5
    '{2'd1,1'b0,16'h0CFC,4'hF,32'h0,32'h0,2'd0,1'b0,8'h00,5'h00,3'd0,6'h00,32'hFFFF_FFFF,8'd5},          // R5
    '{2'd1,1'b1,16'h0CFC,4'hF,32'h0102_0304,32'h0,2'd0,1'b0,8'h00,5'h00,3'd0,6'h00,32'h0,8'd5},          // R5
    '{2'd1,1'b0,16'h0080,4'hF,32'h0,32'h0,2'd0,1'b0,8'h00,5'h00,3'd0,6'h00,32'hFFFF_FFFF,8'd9},          // R9
    '{2'd1,1'b0,16'hC53C,4'hF,32'h0,32'h0,2'd0,1'b0,8'h00,5'h00,3'd0,6'h00,32'hFFFF_FFFF,8'd9},          // R9
    '{2'd2,1'b1,16'h0CF8,4'h1,32'h0000_00F6,32'h0,2'd0,1'b0,8'h00,5'h00,3'd0,6'h00,32'h0,8'd6},          // R6
    '{2'd2,1'b1,16'h0CFA,4'h4,32'h0023_0000,32'h0,2'd0,1'b0,8'h00,5'h00,3'd0,6'h00,32'h0,8'd6},          // R6
    '{2'd2,1'b0,16'h0CF8,4'hF,32'h0,32'h0,2'd0,1'b0,8'h00,5'h00,3'd0,6'h00,32'h0023_00F6,8'd6},          // R6
    '{2'd2,1'b0,16'hC53C,4'hF,32'h0,32'h1234_5678,2'd1,1'b1,8'h23,5'h05,3'd3,6'h0F,32'h1234_5678,8'd7},  // R7
    '{2'd2,1'b1,16'hCF04,4'h3,32'hAAAA_5555,32'h0,2'd3,1'b1,8'h23,5'h0F,3'd3,6'h01,32'h0,8'd7},          // R7
    '{2'd2,1'b1,16'h0CF8,4'h1,32'h0,32'h0,2'd0,1'b0,8'h00,5'h00,3'd0,6'h00,32'h0,8'd6},                  // R6
    '{2'd2,1'b0,16'h0CF8,4'hF,32'h0,32'h0,2'd0,1'b0,8'h00,5'h00,3'd0,6'h00,32'h0023_0000,8'd6},          // R6
    '{2'd2,1'b0,16'hC53C,4'hF,32'h0,32'h0,2'd0,1'b0,8'h00,5'h00,3'd0,6'h00,32'hFFFF_FFFF,8'd8},          // R8
    '{2'd2,1'b1,16'hC53C,4'hF,32'h7777_7777,32'h0,2'd0,1'b0,8'h00,5'h00,3'd0,6'h00,32'h0,8'd8},          // R8
    '{2'd2,1'b1,16'h0CFA,4'h4,32'h0,32'h0,2'd0,1'b0,8'h00,5'h00,3'd0,6'h00,32'h0,8'd6},                  // R6
    '{2'd2,1'b0,16'h0CF8,4'hF,32'h0,32'h0,2'd0,1'b0,8'h00,5'h00,3'd0,6'h00,32'h0,8'd6},                  // R6
    '{2'd3,1'b0,16'hC53C,4'hF,32'h0,32'h0,2'd0,1'b0,8'h00,5'h00,3'd0,6'h00,32'hFFFF_FFFF,8'd11},         // R11
    '{2'd0,1'b0,16'h0CF8,4'hF,32'h0,32'h0,2'd0,1'b0,8'h00,5'h00,3'd0,6'h00,32'hFFFF_FFFF,8'd11},         // R11
    '{2'd1,1'b0,16'h0CF8,4'hF,32'h0,32'h0,2'd0,1'b0,8'h00,5'h00,3'd0,6'h00,32'h0,8'd5}                   // R5
  };

  int checks = 0;
  int fails  = 0;

  logic        got_req, hold_bad;
  logic [31:0] rd_val;
  int          wait_cnt;
  logic [59:0] cap;

  function automatic logic [59:0] req_now();
    return {req_write, req_bus, req_dev, req_fn, req_reg, req_be, req_wdata};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_io(input logic [1:0] m, input logic w, input logic [15:0] a,
                       input logic [3:0] b, input logic [31:0] d,
                       input logic [31:0] r, input int dly);
    int  vcnt = 0;
    logic pend = 1'b0;
    got_req = 1'b0; hold_bad = 1'b0; wait_cnt = 0; rd_val = '0;
    @(negedge clk);
    mode = m; io_addr = a; io_be = b; io_wdata = d; io_wr = w; io_rd = !w;
    for (int i = 0; i < 40; i++) begin
      #1;
      if (!io_wait) begin
        rd_val = io_rdata;
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0; req_ready = 1'b0; rsp_valid = 1'b0;
        return;
      end
      wait_cnt++;
      req_ready = 1'b0; rsp_valid = 1'b0;
      if (req_valid) begin
        if (!got_req) begin got_req = 1'b1; cap = req_now(); end
        else if (req_now() != cap) hold_bad = 1'b1;
        if (vcnt >= dly) begin req_ready = 1'b1; pend = 1'b1; end
        vcnt++;
      end else if (pend) begin
        rsp_valid = 1'b1; rsp_rdata = r; pend = 1'b0;
      end
      @(negedge clk);
    end
    io_wr = 1'b0; io_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(!io_wait && !req_valid, "R1 idle after reset", {io_wait, req_valid}, 0);
    do_io(2'd1, 1'b0, 16'h0CF8, 4'hF, 0, 0, 0);
    chk(rd_val == 32'h0, "R1 target reg reset", rd_val, 0);
    do_io(2'd2, 1'b0, 16'h0CF8, 4'hF, 0, 0, 0);
    chk(rd_val == 32'h0, "R1 select/bus bytes reset", rd_val, 0);

    for (int k = 0; k < NV; k++) begin
      vec_t v = VEC[k];
      string tg;
      tg = $sformatf("R%0d vec%0d", v.rq, k);
      do_io(v.mode, v.wr, v.addr, v.be, v.wdata, v.rsp, int'(v.dly));
      chk(got_req == v.ereq, {tg, " request presence"}, got_req, v.ereq);
      if (!v.wr) chk(rd_val == v.erd, {tg, " read data"}, rd_val, v.erd);
      if (v.ereq && got_req) begin
        chk(cap == {v.wr, v.ebus, v.edev, v.efn, v.ereg, v.be, (v.wr ? v.wdata : cap[31:0])},
            {tg, " request fields"}, cap, {v.wr, v.ebus, v.edev, v.efn, v.ereg, v.be, v.wdata});
        // R10 stall length and hold while back-pressured
        chk(wait_cnt == 3 + int'(v.dly), {tg, " R10 stall cycles"}, wait_cnt, 3 + int'(v.dly));
        chk(!hold_bad, {tg, " R10 fields held"}, hold_bad, 0);
      end
      if (!v.ereq) chk(wait_cnt == 0, {tg, " R9 no stall"}, wait_cnt, 0);
    end

    // R10 directed: a stray response while idle completes nothing
    @(negedge clk); rsp_valid = 1'b1; rsp_rdata = 32'h0BAD_0BAD;
    @(negedge clk); rsp_valid = 1'b0;
    #1;
    chk(!req_valid && !io_wait, "R10 stray response ignored", {req_valid, io_wait}, 0);
    do_io(2'd1, 1'b0, 16'h0080, 4'hF, 0, 0, 0);
    chk(rd_val == 32'hFFFF_FFFF, "R10 stray response no read data", rd_val, 32'hFFFF_FFFF);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule